// File: doc/BRIEF.md
# Multi-Mode Operand Address Unit

This unit executes one two-operand accumulate step. It finds a source operand using one of seven addressing modes, adds that operand to a destination register in its own register file, and writes the sum back. The operand can come from the instruction constant, from a register, or from memory. A memory operand takes one read, or two chained reads when the mode dereferences twice. The external memory port returns data one cycle after a read is issued.

A controller loads the register file through a write port while the unit is idle. It presents the mode and operand fields with a one-cycle `start` pulse, then waits for `done`, or for `err` on an illegal mode. Any register can be observed at any time through a combinational read port.

Top module: `opaddr_unit`

## Requirements
- R1: Mode 0 (immediate) adds the 16-bit constant, sign-extended to 32 bits, to the destination register. It issues no memory read, and `done` is high in the second cycle after the `start` edge.
- R2: Mode 1 (register) adds the source register to the destination register. It issues no memory read, and `done` is high in the second cycle after start.
- R3: Mode 2 (register indirect) issues exactly one read, at the address held in the source register, and adds the returned word. `done` is high in the third cycle after start.
- R4: Mode 3 (direct) issues one read at the sign-extended constant and adds the returned word. `done` is high in the third cycle.
- R5: Mode 4 (memory indirect) issues two reads in consecutive cycles. The first read is at the source register. The second read is at the word returned by the first. The unit adds the word returned by the second read. `done` is high in the fourth cycle.
- R6: Mode 5 (displacement) issues one read at the sign-extended constant plus the base (source) register. `done` is high in the third cycle.
- R7: Mode 6 (scaled) issues one read at constant + base + (index register shifted left by `scale_sel`), where `scale_sel` 0,1,2,3 means a factor of 1,2,4,8. `done` is high in the third cycle.
- R8: Mode 7 is illegal. `err` pulses in the first cycle after start. No `done`, no memory read and no register write follow.
- R9: `done` lasts one cycle. `busy` is high from the cycle after an accepted start through the `done` (or `err`) cycle, and is low in the cycle after.
- R10: A `start` pulse while `busy` is high is ignored: the running instruction's result, reads and latency are unchanged.
- R11: After reset all 16 registers read zero, and `busy`, `done`, `err` and `mem_rd` are low.
- R12: Register 0 is an ordinary register, and a destination equal to the source uses the source value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| mode | input | 3 | Addressing mode code |
| dst_idx | input | 4 | Destination register |
| src_idx | input | 4 | Source / base register |
| idx_idx | input | 4 | Index register for scaled mode |
| imm | input | 16 | Immediate or displacement constant |
| scale_sel | input | 2 | Index shift amount |
| wr_en | input | 1 | Register load strobe (idle only) |
| wr_idx | input | 4 | Register load index |
| wr_data | input | 32 | Register load value |
| rd_idx | input | 4 | Observation read index |
| rd_data | output | 32 | Observed register value |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Writeback cycle |
| err | output | 1 | Illegal mode flagged |

## Verification
A wrong sequencer state shows first as the wrong number of `mem_rd` cycles, or as a `done` arriving one cycle early or late. Both are visible within four cycles of `start`. A wrong address computation shows on `mem_addr` in the same cycle as the read. A wrong operand or writeback target shows at `rd_data` one cycle after `done`. The bench compares every read address, the cycle in which `done` or `err` arrives, and the destination value for each instruction.

// File: rtl/opaddr_unit.sv
module opaddr_unit #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int IMMW = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [IW-1:0] dst_idx,
  input  logic [IW-1:0] src_idx,
  input  logic [IW-1:0] idx_idx,
  input  logic [IMMW-1:0] imm,
  input  logic [1:0]    scale_sel,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          mem_rd,
  output logic [DW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          err
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_MEM1, S_MEM2, S_EXEC} st_t;

  st_t           st;
  logic [DW-1:0] rf [NREG];
  logic [2:0]    m_q;
  logic [IW-1:0] d_q, s_q, x_q;
  logic [DW-1:0] k_q, opnd_q, ea;
  logic [1:0]    sc_q;
  logic          uses_mem;

  assign uses_mem = (m_q >= 3'd2) && (m_q <= 3'd6);

  always_comb begin
    case (m_q)
      3'd3:    ea = k_q;
      3'd5:    ea = k_q + rf[s_q];
      3'd6:    ea = k_q + rf[s_q] + (rf[x_q] << sc_q);
      default: ea = rf[s_q];
    endcase
  end

  assign mem_rd   = (st == S_ADDR && uses_mem) || (st == S_MEM1 && m_q == 3'd4);
  assign mem_addr = (st == S_MEM1) ? mem_rdata : ea;
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_EXEC);
  assign err      = (st == S_ADDR) && (m_q == 3'd7);
  assign rd_data  = rf[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      m_q    <= '0;
      d_q    <= '0;
      s_q    <= '0;
      x_q    <= '0;
      k_q    <= '0;
      sc_q   <= '0;
      opnd_q <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (wr_en) rf[wr_idx] <= wr_data;
          if (start) begin
            m_q  <= mode;
            d_q  <= dst_idx;
            s_q  <= src_idx;
            x_q  <= idx_idx;
            k_q  <= {{(DW-IMMW){imm[IMMW-1]}}, imm};
            sc_q <= scale_sel;
            st   <= S_ADDR;
          end
        end
        S_ADDR: begin
          if (m_q == 3'd7)      st <= S_IDLE;
          else if (uses_mem)    st <= S_MEM1;
          else begin
            opnd_q <= (m_q == 3'd0) ? k_q : rf[s_q];
            st     <= S_EXEC;
          end
        end
        S_MEM1: begin
          if (m_q == 3'd4) st <= S_MEM2;
          else begin
            opnd_q <= mem_rdata;
            st     <= S_EXEC;
          end
        end
        S_MEM2: begin
          opnd_q <= mem_rdata;
          st     <= S_EXEC;
        end
        S_EXEC: begin
          rf[d_q] <= rf[d_q] + opnd_q;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module opaddr_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic err,
  input logic mem_rd
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_frees_r9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  p_start_takes_r9: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  p_err_alone_r8: assert property (@(posedge clk) disable iff (!rst_n) err |-> (!done && !mem_rd));
  p_err_frees_r8: assert property (@(posedge clk) disable iff (!rst_n) err |=> !busy);
  p_read_not_last_r5: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> !done);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!done && !err && !mem_rd));
endmodule

bind opaddr_unit opaddr_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .err(err), .mem_rd(mem_rd)
);

// File: tb/opaddr_unit_tb_top.sv
`timescale 1ns/1ps
module opaddr_unit_tb_top;
  logic        clk = 0, rst_n = 0, start = 0, wr_en = 0;
  logic [2:0]  mode = 0;
  logic [3:0]  dst_idx = 0, src_idx = 0, idx_idx = 0, wr_idx = 0, rd_idx = 0;
  logic [15:0] imm = 0;
  logic [1:0]  scale_sel = 0;
  logic [31:0] wr_data = 0, rd_data, mem_addr, mem_rdata = 0;
  logic        mem_rd, busy, done, err;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] e [16];

  always #2 clk = ~clk;

  opaddr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .dst_idx(dst_idx),
    .src_idx(src_idx), .idx_idx(idx_idx), .imm(imm), .scale_sel(scale_sel),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
    .rd_data(rd_data), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .err(err)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag(input int m);
    case (m)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
      4: return "R5"; 5: return "R6"; 6: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic wr_reg(input int i, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(i); wr_data = v;
    @(negedge clk);
    wr_en = 0;
    e[i] = v;
  endtask

  task automatic run(input int m, input int d, input int s, input int x,
                     input logic [15:0] k, input int sc, input bit inject);
    logic [31:0] sx, op, a1, a2, got_a [4];
    int nrd, lat, got_n, got_lat;
    bit got_err;
    sx = {{16{k[15]}}, k};
    a1 = 0; a2 = 0; op = 0; nrd = 0; lat = 3;
    case (m)
      0: begin op = sx; lat = 2; end
      1: begin op = e[s]; lat = 2; end
      2: begin a1 = e[s]; nrd = 1; end
      3: begin a1 = sx; nrd = 1; end
      4: begin a1 = e[s]; a2 = memf(a1); nrd = 2; lat = 4; end
      5: begin a1 = sx + e[s]; nrd = 1; end
      6: begin a1 = sx + e[s] + (e[x] << sc); nrd = 1; end
      default: lat = 1;
    endcase
    if (nrd > 0) op = memf(nrd == 2 ? a2 : a1);
    @(negedge clk);
    mode = 3'(m); dst_idx = 4'(d); src_idx = 4'(s); idx_idx = 4'(x);
    imm = k; scale_sel = 2'(sc); start = 1;
    got_n = 0; got_lat = 0; got_err = 0;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      start = 0;
      if (inject && c == 1) begin
        start = 1; mode = 3'd0; imm = 16'h0100; dst_idx = 4'(d + 1);
      end
      if (mem_rd) begin
        if (got_n < 4) got_a[got_n] = mem_addr;
        got_n++;
      end
      if (done || err) begin
        got_lat = c; got_err = err;
        break;
      end
    end
    start = 0;
    chk({tag(m), inject ? "/R10 latency" : " latency"}, 32'(got_lat), 32'(lat));
    chk({tag(m), " err flag"}, 32'(got_err), 32'(m == 7));
    chk({tag(m), " read count"}, 32'(got_n), 32'(nrd));
    if (nrd >= 1 && got_n >= 1) chk({tag(m), " first address"}, got_a[0], a1);
    if (nrd == 2 && got_n >= 2) chk("R5 second address", got_a[1], a2);
    if (m != 7) e[d] = e[d] + op;
    @(negedge clk);
    chk("R9 busy clear after finish", 32'(busy), 32'd0);
    rd_idx = 4'(d);
    #0.5;
    chk({tag(m), inject ? "/R10 dest value" : " dest value"}, rd_data, e[d]);
    if (inject) begin
      rd_idx = 4'(d + 1);
      #0.5;
      chk("R10 injected start had no effect", rd_data, e[(d + 1) % 16]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i);
      #0.5;
      chk("R11 register reset", rd_data, 32'd0);
    end
    chk("R11 idle outputs", {28'd0, busy, done, err, mem_rd}, 32'd0);
    for (int i = 0; i < 16; i++) wr_reg(i, 32'h0000_1000 * i + 32'h35 * i + 32'h7);
    for (int m = 0; m < 8; m++)
      for (int sc = 0; sc < 4; sc++)
        for (int p = 0; p < 3; p++)
          run(m, (m * 3 + p * 5 + sc) % 16, (m + p * 7 + sc * 3 + 1) % 16,
              (p * 4 + sc + 2) % 16,
              p == 0 ? 16'h0007 : (p == 1 ? 16'hFF80 : 16'(16'h7FF0 + m)),
              sc, p == 2);
    // R12: register 0 as destination and source together
    wr_reg(0, 32'h0000_0021);
    run(1, 0, 0, 0, 16'h0, 0, 0);
    run(4, 0, 0, 0, 16'h0, 0, 0);
    run(6, 5, 5, 5, 16'hFFFF, 3, 0);
    chk("R12 register 0 doubled then accumulated", e[0] == 32'h42 + memf(memf(32'h42)), 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule